// File: doc/BRIEF.md
# Critical-Word-First Instruction Line Filler

This block refills one instruction cache line after a miss. The fetch stage presents a miss address for one cycle. The block then reads every word of the line that holds that address from external memory. It starts at the missed word, moves up to the top of the line and wraps back to word zero until every word has arrived. Each returned word goes to the line storage together with its index inside the line. A one-cycle strobe marks the arrival of the missed word, so the fetch stage can restart while the rest of the line is still filling.

A parameter selects how memory is read. In burst mode the block issues one wrapping read request that carries the critical-word address and a count equal to the line length. In single mode it issues one single-word request for each word. The words arrive in the same order in both modes. The memory side is a read-request interface with waitrequest and a read-data-valid strobe. While a fill is in progress the block reports busy and ignores new misses.

Top module: `line_filler`

## Requirements
- R1: After reset, and whenever busy is low, the block holds mem_read, line_we and crit_valid low and has no request outstanding.
- R2: The address of the first memory request is the line base plus the critical word index times BYTES_PER_WORD, and its low log2(BYTES_PER_WORD) bits are zero.
- R3: During a fill, line_idx takes the values (c, c+1, ..., WORDS_PER_LINE-1, 0, ..., c-1), where c is miss_addr bits [log2(BYTES_PER_WORD) +: log2(WORDS_PER_LINE)]. An aligned miss (c = 0) therefore fills in ascending order, and a miss at byte offset 8 of a 32-byte line fills in the byte order 8, 12, 16, 20, 24, 28, 0, 4.
- R4: crit_valid is high for exactly one cycle per fill. That cycle is the one in which the first word is written, and line_idx then equals the critical index.
- R5: With BURST_EN=1 a fill makes one accepted request with mem_burstcount = WORDS_PER_LINE. With BURST_EN=0 it makes WORDS_PER_LINE accepted requests, each with mem_burstcount = 1, whose addresses follow the order of R3.
- R6: While mem_read is high and mem_waitrequest is high, the request stays asserted in the next cycle with mem_addr and mem_burstcount unchanged.
- R7: Each fill writes exactly WORDS_PER_LINE words. fill_done is high for one cycle, in the cycle after the last write, and busy is low in that cycle.
- R8: A miss_valid pulse that arrives while busy is high is ignored. The running fill keeps its order and requests, and no second fill follows.
- R9: The byte-offset bits of miss_addr have no effect. A miss at offset 3 within a word fills exactly as the aligned miss does, and every request address has zero byte-offset bits.
- R10: line_wdata equals mem_readdata in each cycle where line_we is high. line_we is high only when mem_readdatavalid is high while the block waits for data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Start a fill (taken only when idle) |
| miss_addr | input | ADDR_W | Byte address of the missed instruction |
| busy | output | 1 | A fill is in progress |
| mem_read | output | 1 | Read request to memory |
| mem_addr | output | ADDR_W | Request byte address |
| mem_burstcount | output | log2(WORDS_PER_LINE)+1 | Words requested |
| mem_waitrequest | input | 1 | Memory stalls the current request |
| mem_readdatavalid | input | 1 | Returned word is valid |
| mem_readdata | input | DATA_W | Returned word |
| line_we | output | 1 | Write strobe to line storage |
| line_idx | output | log2(WORDS_PER_LINE) | Word index inside the line |
| line_wdata | output | DATA_W | Word to store |
| crit_valid | output | 1 | The critical word is being written |
| fill_done | output | 1 | The line is complete |

## Verification
A miss driven before a clock edge raises busy and mem_read after that edge. A request accepted at an edge lets the memory model return data from the next cycle on. line_we, line_idx, line_wdata and crit_valid follow mem_readdatavalid in the same cycle, and fill_done comes one edge after the last write. The bench drives inputs just after the falling edge and logs every output at falling edges. It checks each fill only after fill_done, against the full order it expects, so waitrequest stalls and data gaps move no sample point. One fill runs in a burst-mode instance and in a single-mode instance at the same time, and both are checked.

// File: rtl/lf_pkg.sv
package lf_pkg;
    typedef enum logic [1:0] {
        LF_IDLE = 2'd0,
        LF_REQ  = 2'd1,
        LF_WAIT = 2'd2
    } lf_state_e;
endpackage

// File: rtl/lf_wrap_idx.sv
// Line-relative index: base plus step, wrapped at the line length (power of two).
module lf_wrap_idx #(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] base,
    input  logic [IDX_W-1:0] step,
    output logic [IDX_W-1:0] idx
);
    assign idx = base + step;
endmodule

// File: rtl/lf_addr_join.sv
// Builds a word-aligned byte address from the line tag and a word index.
module lf_addr_join #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2
) (
    input  logic [ADDR_W-IDX_W-OFF_W-1:0] line_tag,
    input  logic [IDX_W-1:0]              word_idx,
    output logic [ADDR_W-1:0]             byte_addr
);
    assign byte_addr = {line_tag, word_idx, {OFF_W{1'b0}}};
endmodule

// File: rtl/line_filler.sv
module line_filler #(
    parameter int ADDR_W         = 32,
    parameter int DATA_W         = 32,
    parameter int BYTES_PER_WORD = 4,
    parameter int WORDS_PER_LINE = 8,
    parameter bit BURST_EN       = 1'b1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                miss_valid,
    input  logic [ADDR_W-1:0]                   miss_addr,
    output logic                                busy,
    output logic                                mem_read,
    output logic [ADDR_W-1:0]                   mem_addr,
    output logic [$clog2(WORDS_PER_LINE):0]     mem_burstcount,
    input  logic                                mem_waitrequest,
    input  logic                                mem_readdatavalid,
    input  logic [DATA_W-1:0]                   mem_readdata,
    output logic                                line_we,
    output logic [$clog2(WORDS_PER_LINE)-1:0]   line_idx,
    output logic [DATA_W-1:0]                   line_wdata,
    output logic                                crit_valid,
    output logic                                fill_done
);
    import lf_pkg::*;

    localparam int OFF_W = $clog2(BYTES_PER_WORD);
    localparam int IDX_W = $clog2(WORDS_PER_LINE);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int CNT_W = IDX_W + 1;
    localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(WORDS_PER_LINE - 1);

    typedef struct packed {
        lf_state_e         state;
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  start;
        logic [IDX_W-1:0]  beat;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  req_idx;
    logic [CNT_W-1:0]  req_count;
    logic [ADDR_W-1:0] req_addr;
    logic              unused_offset;

    assign unused_offset = ^miss_addr[OFF_W-1:0];

    // Index of the word now arriving: critical index plus beats already stored.
    lf_wrap_idx #(.IDX_W(IDX_W)) u_wr_wrap (
        .base (r_q.start),
        .step (r_q.beat),
        .idx  (wr_idx)
    );

    generate
        if (BURST_EN) begin : g_burst
            // One wrapping burst that starts at the critical word.
            assign req_idx   = r_q.start;
            assign req_count = CNT_W'(WORDS_PER_LINE);
        end else begin : g_single
            // One word per request, taken in the wrapped order.
            assign req_idx   = wr_idx;
            assign req_count = CNT_W'(1);
        end
    endgenerate

    lf_addr_join #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_join (
        .line_tag  (r_q.tag),
        .word_idx  (req_idx),
        .byte_addr (req_addr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            LF_IDLE: begin
                if (miss_valid) begin
                    r_d.tag   = miss_addr[ADDR_W-1 -: TAG_W];
                    r_d.start = miss_addr[OFF_W +: IDX_W];
                    r_d.beat  = '0;
                    r_d.state = LF_REQ;
                end
            end
            LF_REQ: begin
                if (!mem_waitrequest) begin
                    r_d.state = LF_WAIT;
                end
            end
            LF_WAIT: begin
                if (mem_readdatavalid) begin
                    if (r_q.beat == LAST_BEAT) begin
                        r_d.state = LF_IDLE;
                        r_d.beat  = '0;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.beat = r_q.beat + 1'b1;
                        if (!BURST_EN) begin
                            r_d.state = LF_REQ;
                        end
                    end
                end
            end
            default: r_d.state = LF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: LF_IDLE, tag: '0, start: '0, beat: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy           = (r_q.state != LF_IDLE);
    assign mem_read       = (r_q.state == LF_REQ);
    assign mem_addr       = req_addr;
    assign mem_burstcount = req_count;
    assign line_we        = (r_q.state == LF_WAIT) && mem_readdatavalid;
    assign line_idx       = wr_idx;
    assign line_wdata     = mem_readdata;
    assign crit_valid     = line_we && (r_q.beat == '0);
    assign fill_done      = r_q.done;
endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
    parameter int ADDR_W         = 32,
    parameter int BYTES_PER_WORD = 4,
    parameter int WORDS_PER_LINE = 8,
    parameter bit BURST_EN       = 1'b1
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              busy,
    input logic                              mem_read,
    input logic [ADDR_W-1:0]                 mem_addr,
    input logic [$clog2(WORDS_PER_LINE):0]   mem_burstcount,
    input logic                              mem_waitrequest,
    input logic                              line_we,
    input logic [$clog2(WORDS_PER_LINE)-1:0] line_idx,
    input logic                              crit_valid,
    input logic                              fill_done
);
    localparam int OFF_W = $clog2(BYTES_PER_WORD);
    localparam int IDX_W = $clog2(WORDS_PER_LINE);
    localparam int CNT_W = IDX_W + 1;

    logic             seen;
    logic [IDX_W-1:0] last_idx;
    logic [CNT_W-1:0] nwr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            last_idx <= '0;
            nwr      <= '0;
        end else if (fill_done) begin
            seen <= 1'b0;
            nwr  <= '0;
        end else if (line_we) begin
            seen     <= 1'b1;
            last_idx <= line_idx;
            nwr      <= nwr + 1'b1;
        end
    end

    // R1: nothing moves on the memory or storage side while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_read && !line_we && !crit_valid));

    // R2, R9: requests are word aligned
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_read |-> (mem_addr[OFF_W-1:0] == '0));

    // R3: each stored index follows the previous one, modulo the line
    a_r3_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
        (line_we && seen) |-> (line_idx == IDX_W'(last_idx + 1'b1)));

    // R4: the strobe marks the first write of a fill and no other
    a_r4_crit_first: assert property (@(posedge clk) disable iff (!rst_n)
        line_we |-> (crit_valid == !seen));

    // R5: request length matches the mode; bursts ask once, before any data
    a_r5_count: assert property (@(posedge clk) disable iff (!rst_n)
        mem_read |-> (mem_burstcount == (BURST_EN ? CNT_W'(WORDS_PER_LINE) : CNT_W'(1))));

    a_r5_one_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (BURST_EN && mem_read) |-> (nwr == '0));

    // R6: a stalled request is held unchanged
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_read && mem_waitrequest) |=>
            (mem_read && $stable(mem_addr) && $stable(mem_burstcount)));

    // R7: completion follows a full line, one cycle after the last write
    a_r7_done: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> (nwr == CNT_W'(WORDS_PER_LINE) && !busy && !line_we));

    a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_done) |-> $past(line_we));
endmodule

bind line_filler lf_checker #(
    .ADDR_W         (ADDR_W),
    .BYTES_PER_WORD (BYTES_PER_WORD),
    .WORDS_PER_LINE (WORDS_PER_LINE),
    .BURST_EN       (BURST_EN)
) u_lf_checker (.*);

// File: tb/lf_mem_model.sv
// Memory responder and output logger for one filler instance (8-word lines, 4-byte words).
module lf_mem_model (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic [3:0]  stall_n,
    input  logic        gap_en,
    input  logic        mem_read,
    input  logic [31:0] mem_addr,
    input  logic [3:0]  mem_burstcount,
    output logic        mem_waitrequest,
    output logic        mem_readdatavalid,
    output logic [31:0] mem_readdata,
    input  logic        line_we,
    input  logic [2:0]  line_idx,
    input  logic [31:0] line_wdata,
    input  logic        crit_valid,
    input  logic        fill_done
);
    logic [3:0]  pend;
    logic [3:0]  wcnt;
    logic [31:0] cur;
    logic        phase;

    int          log_idx  [16];
    logic [31:0] log_data [16];
    int          nlog, crit_n, crit_pos, done_n, done_good, req_n, hold_bad;
    logic [31:0] req_addr [16];
    int          req_bc   [16];
    logic        prev_we, prev_stall;
    logic [31:0] prev_addr;

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pend              <= '0;
            wcnt              <= '0;
            cur               <= '0;
            phase             <= 1'b0;
            mem_waitrequest   <= 1'b0;
            mem_readdatavalid <= 1'b0;
            mem_readdata      <= '0;
        end else begin
            mem_readdatavalid <= 1'b0;
            if (pend != 0) begin
                phase <= ~phase;
                if (!gap_en || phase) begin
                    mem_readdatavalid <= 1'b1;
                    mem_readdata      <= word_at(cur);
                    cur               <= {cur[31:5], cur[4:2] + 3'd1, 2'b00};
                    pend              <= pend - 4'd1;
                end
            end
            if (!mem_read) begin
                mem_waitrequest <= (stall_n != 0);
                wcnt            <= '0;
            end else if (!mem_waitrequest) begin
                pend  <= mem_burstcount;
                cur   <= mem_addr;
                phase <= 1'b0;
                wcnt  <= '0;
            end else begin
                wcnt <= wcnt + 4'd1;
                if (wcnt + 4'd1 >= stall_n) mem_waitrequest <= 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (clr) begin
            nlog = 0; crit_n = 0; crit_pos = -1; done_n = 0; done_good = 0;
            req_n = 0; hold_bad = 0; prev_we = 1'b0; prev_stall = 1'b0;
        end else begin
            if (prev_stall && !(mem_read && mem_addr == prev_addr)) hold_bad++;
            prev_stall = mem_read && mem_waitrequest;
            prev_addr  = mem_addr;
            if (mem_read && !mem_waitrequest && req_n < 16) begin
                req_addr[req_n] = mem_addr;
                req_bc[req_n]   = int'(mem_burstcount);
                req_n++;
            end
            if (crit_valid) begin
                crit_n++;
                crit_pos = nlog;
            end
            if (fill_done) begin
                done_n++;
                if (prev_we) done_good++;
            end
            if (line_we && nlog < 16) begin
                log_idx[nlog]  = int'(line_idx);
                log_data[nlog] = line_wdata;
                nlog++;
            end
            if (line_we && !mem_readdatavalid) hold_bad += 100;
            prev_we = line_we;
        end
    end
endmodule

// File: tb/line_filler_test.sv
module line_filler_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b1;
    logic [3:0]  stall_n = 4'd0;
    logic        gap_en = 1'b0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_addr = '0;

    logic        b_busy, b_read, b_wait, b_rdv, b_we, b_crit, b_done;
    logic [31:0] b_addr, b_rdata, b_wdata;
    logic [3:0]  b_bc;
    logic [2:0]  b_idx;
    logic        s_busy, s_read, s_wait, s_rdv, s_we, s_crit, s_done;
    logic [31:0] s_addr, s_rdata, s_wdata;
    logic [3:0]  s_bc;
    logic [2:0]  s_idx;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    line_filler #(.BURST_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .busy(b_busy), .mem_read(b_read), .mem_addr(b_addr), .mem_burstcount(b_bc),
        .mem_waitrequest(b_wait), .mem_readdatavalid(b_rdv), .mem_readdata(b_rdata),
        .line_we(b_we), .line_idx(b_idx), .line_wdata(b_wdata),
        .crit_valid(b_crit), .fill_done(b_done));

    line_filler #(.BURST_EN(1'b0)) uut_s (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .busy(s_busy), .mem_read(s_read), .mem_addr(s_addr), .mem_burstcount(s_bc),
        .mem_waitrequest(s_wait), .mem_readdatavalid(s_rdv), .mem_readdata(s_rdata),
        .line_we(s_we), .line_idx(s_idx), .line_wdata(s_wdata),
        .crit_valid(s_crit), .fill_done(s_done));

    lf_mem_model mdl_b (
        .clk(clk), .rst_n(rst_n), .clr(clr), .stall_n(stall_n), .gap_en(gap_en),
        .mem_read(b_read), .mem_addr(b_addr), .mem_burstcount(b_bc),
        .mem_waitrequest(b_wait), .mem_readdatavalid(b_rdv), .mem_readdata(b_rdata),
        .line_we(b_we), .line_idx(b_idx), .line_wdata(b_wdata),
        .crit_valid(b_crit), .fill_done(b_done));

    lf_mem_model mdl_s (
        .clk(clk), .rst_n(rst_n), .clr(clr), .stall_n(stall_n), .gap_en(gap_en),
        .mem_read(s_read), .mem_addr(s_addr), .mem_burstcount(s_bc),
        .mem_waitrequest(s_wait), .mem_readdatavalid(s_rdv), .mem_readdata(s_rdata),
        .line_we(s_we), .line_idx(s_idx), .line_wdata(s_wdata),
        .crit_valid(s_crit), .fill_done(s_done));

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic begin_fill(input logic [31:0] a);
        clr = 1'b1;
        step();
        clr = 1'b0;
        miss_valid = 1'b1;
        miss_addr  = a;
        step();
        miss_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while ((mdl_b.done_n == 0 || mdl_s.done_n == 0) && n < 400) begin
            step();
            n++;
        end
        chk(n < 400, "R7 fill completes", n, 400);
        step();
    endtask

    // Compare one instance's logged fill against the order expected for address a.
    task automatic verify(input bit single, input logic [31:0] a);
        logic [31:0] base = {a[31:5], 5'b0};
        int st = int'(a[4:2]);
        int nlog, crit_n, crit_pos, done_n, done_good, req_n, hold_bad;
        int lidx [16];
        logic [31:0] ldat [16];
        logic [31:0] raddr [16];
        int rbc [16];
        int bad_idx = 0, bad_dat = 0, bad_req = 0;
        string md = single ? "single" : "burst";
        if (single) begin
            nlog = mdl_s.nlog; crit_n = mdl_s.crit_n; crit_pos = mdl_s.crit_pos;
            done_n = mdl_s.done_n; done_good = mdl_s.done_good;
            req_n = mdl_s.req_n; hold_bad = mdl_s.hold_bad;
            for (int k = 0; k < 16; k++) begin
                lidx[k] = mdl_s.log_idx[k]; ldat[k] = mdl_s.log_data[k];
                raddr[k] = mdl_s.req_addr[k]; rbc[k] = mdl_s.req_bc[k];
            end
        end else begin
            nlog = mdl_b.nlog; crit_n = mdl_b.crit_n; crit_pos = mdl_b.crit_pos;
            done_n = mdl_b.done_n; done_good = mdl_b.done_good;
            req_n = mdl_b.req_n; hold_bad = mdl_b.hold_bad;
            for (int k = 0; k < 16; k++) begin
                lidx[k] = mdl_b.log_idx[k]; ldat[k] = mdl_b.log_data[k];
                raddr[k] = mdl_b.req_addr[k]; rbc[k] = mdl_b.req_bc[k];
            end
        end
        chk(nlog == 8, {"R7 word count ", md}, nlog, 8);
        for (int k = 0; k < 8 && k < nlog; k++) begin
            int e = (st + k) % 8;
            if (lidx[k] != e) bad_idx++;
            if (ldat[k] !== word_at(base + 32'(e * 4))) bad_dat++;
        end
        chk(bad_idx == 0, {"R3 wrapped index order ", md}, bad_idx, 0);
        chk(bad_dat == 0, {"R10 stored data ", md}, bad_dat, 0);
        chk(crit_n == 1 && crit_pos == 0, {"R4 critical strobe ", md}, crit_n, 1);
        chk(done_n == 1 && done_good == 1, {"R7 done after last write ", md}, done_good, 1);
        chk(hold_bad == 0, {"R6 R10 stalled request held ", md}, hold_bad, 0);
        chk(raddr[0] === base + 32'(st * 4), {"R2 first request address ", md},
            raddr[0], base + 32'(st * 4));
        if (single) begin
            chk(req_n == 8, "R5 single request count", req_n, 8);
            for (int k = 0; k < 8 && k < req_n; k++) begin
                if (raddr[k] !== base + 32'(((st + k) % 8) * 4) || rbc[k] != 1) bad_req++;
            end
            chk(bad_req == 0, "R5 single request order and length", bad_req, 0);
        end else begin
            chk(req_n == 1, "R5 burst request count", req_n, 1);
            chk(rbc[0] == 8, "R5 burst length", rbc[0], 8);
        end
        chk(!(single ? s_busy : b_busy), {"R7 busy cleared ", md}, 1, 0);
    endtask

    task automatic run_fill(input logic [31:0] a, input logic [31:0] exp_a);
        begin_fill(a);
        wait_done();
        verify(1'b0, exp_a);
        verify(1'b1, exp_a);
    endtask

    task automatic t_reset();
        chk(!b_busy && !s_busy, "R1 busy low in reset", {b_busy, s_busy}, 0);
        chk(!b_read && !s_read && !b_we && !s_we, "R1 no request in reset",
            {b_read, s_read, b_we, s_we}, 0);
        rst_n = 1'b1;
        step(); step();
        chk(!b_busy && !s_busy && !b_read && !s_read && !b_crit && !s_crit,
            "R1 idle after reset", {b_busy, s_busy, b_read, s_read}, 0);
    endtask

    task automatic t_aligned();   run_fill(32'h0000_1000, 32'h0000_1000); endtask
    task automatic t_mid_line();  run_fill(32'h0000_2008, 32'h0000_2008); endtask
    task automatic t_last_word(); run_fill(32'h0000_301C, 32'h0000_301C); endtask

    task automatic t_stalls();
        stall_n = 4'd2;
        gap_en  = 1'b1;
        run_fill(32'h0000_4014, 32'h0000_4014);
        stall_n = 4'd0;
        gap_en  = 1'b0;
    endtask

    // R9: offset bits 3 within the word must behave as the aligned word
    task automatic t_offset_bits(); run_fill(32'h0000_500B, 32'h0000_5008); endtask

    // R8: second miss during a fill
    task automatic t_busy_ignore();
        stall_n = 4'd1;
        begin_fill(32'h0000_6004);
        step(); step();
        chk(b_busy && s_busy, "R8 busy during fill", {b_busy, s_busy}, 2'b11);
        miss_valid = 1'b1;
        miss_addr  = 32'h0000_7010;
        step();
        miss_valid = 1'b0;
        wait_done();
        verify(1'b0, 32'h0000_6004);
        verify(1'b1, 32'h0000_6004);
        repeat (20) step();
        chk(mdl_b.done_n == 1 && mdl_s.done_n == 1, "R8 no second fill",
            mdl_b.done_n + mdl_s.done_n, 2);
        chk(!b_busy && !s_busy && !b_read && !s_read, "R8 idle after ignored miss",
            {b_busy, s_busy, b_read, s_read}, 0);
        stall_n = 4'd0;
    endtask

    initial begin
        step();
        clr = 1'b0;
        step();
        t_reset();
        t_aligned();
        t_mid_line();
        t_last_word();
        t_stalls();
        t_offset_bits();
        t_busy_ignore();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule